// File: doc/BRIEF.md
# Configurable Digital I/O Port with Pin-Change Interrupt

This block is a small general-purpose digital port of eight pins by default. Software decides pin by pin whether a pin drives a level or samples one. A driven pin takes its level from a data register. A sampled pin is brought through a two-stage synchronizer, and its level can be read back through the same data register. The block drives an output-enable vector and an output-value vector toward the pad ring, and it receives the raw pad levels.

Any sampled pin can also act as an interrupt source. When the level of an enabled input pin changes in either direction, the block sets that pin's bit in a flag register and raises a single interrupt line. The handler reads the flag register to find the source pins. The read clears the register, except for a change that arrives in the same cycle, which is kept.

Software reaches the port through a simple synchronous register interface with four word addresses. Read data appears on the cycle after the read strobe.

Top module: `dio_port`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all 0), `pad_out` is 0, the flag register is 0 and `irq_o` is 0.
- R2: The direction register is at address 0. Bit i set to 1 makes pin i an output and drives `pad_oe[i]` high on the cycle after the write, and 0 makes it an input. The register reads back at address 0, with read data valid one cycle after the strobe.
- R3: A write to the data register at address 1 updates `pad_out[i]` only for pins whose direction bit is 1. Bits of input pins keep their previous value.
- R4: A read of address 1 returns, for each output pin, its driven value and, for each input pin, its pad level after two synchronizer flops.
- R5: A flag bit is set on a rising or a falling change of a pin only when the pin is an input and its enable bit is set in the interrupt-enable register at address 2. Changes on outputs or on non-enabled inputs set nothing.
- R6: `irq_o` is high exactly when at least one flag bit is set, and it stays high until the flags are cleared.
- R7: A read of the flag register at address 3 returns the flags and clears them all. A pin change flagged in the same cycle as the read survives the clear.
- R8: The interrupt-enable register is write-only and reads as 0. The flag register is read-only, and writes to it have no effect.
- R9: A pad change made between clock edges sets its flag, and raises `irq_o`, on the third rising edge after the change and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word address: 0 direction, 1 data, 2 interrupt enable, 3 flags |
| bus_wdata | input | DW (16) | Write data; low NPINS bits are used |
| bus_rdata | output | DW (16) | Registered read data |
| pad_in | input | NPINS (8) | Raw pin levels from the pads |
| pad_out | output | NPINS (8) | Levels to drive on output pins |
| pad_oe | output | NPINS (8) | Output enables, 1 = drive |
| irq_o | output | 1 | Peripheral interrupt request |

## Verification
The bench builds the port with its defaults: eight pins, a 16-bit data bus and a two-flop synchronizer. With eight pins, a set of mixed direction masks covers each pin both as an output and as an input, and it shows that data writes leave the input pins' bits unchanged. The two-stage synchronizer gives a fixed three-edge latency from a pad change to its flag. The bench can therefore place a flag read in exactly the cycle where a new change is captured, and it checks that the new flag survives the clear.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 2'd0,
    REG_DATA = 2'd1,
    REG_IEN  = 2'd2,
    REG_FLAG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/dio_regs.sv
module dio_regs
  import dio_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int DW    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  pin_level,
  input  logic [NPINS-1:0]  flags,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  ien_q
);
  localparam int PAD_W = DW - NPINS;

  logic             wr_en, rd_en;
  logic [NPINS-1:0] wbits;
  logic [NPINS-1:0] rd_bits;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & bus_rd;
  assign wbits = bus_wdata[NPINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(bus_addr))
        REG_DIR:  dir_q <= wbits;
        REG_DATA: out_q <= (wbits & dir_q) | (out_q & ~dir_q);
        REG_IEN:  ien_q <= wbits;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_DIR:  rd_bits = dir_q;
      REG_DATA: rd_bits = (dir_q & out_q) | (~dir_q & pin_level);
      REG_FLAG: rd_bits = flags;
      default:  rd_bits = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= {{PAD_W{1'b0}}, rd_bits};
  end
endmodule

// File: rtl/dio_flags.sv
module dio_flags #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_level,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] ien_q,
  input  logic             flag_rd,
  output logic [NPINS-1:0] change,
  output logic [NPINS-1:0] flag_q,
  output logic             irq_q
);
  logic [NPINS-1:0] last_q;
  logic [NPINS-1:0] flag_d;

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= pin_level;
  end

  assign change = (pin_level ^ last_q) & ien_q & ~dir_q;
  assign flag_d = (flag_rd ? '0 : flag_q) | change;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= |flag_d;
    end
  end
endmodule

// File: rtl/dio_port.sv
module dio_port
  import dio_pkg::*;
#(
  parameter int NPINS     = 8,
  parameter int DW        = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_o
);
  logic [NPINS-1:0] pin_level;
  logic [NPINS-1:0] dir_q, out_q, ien_q;
  logic [NPINS-1:0] flag_q, change;
  logic             flag_rd;

  assign flag_rd = bus_sel & bus_rd & (bus_addr == REG_FLAG);

  dio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STGS)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_in   (pad_in),
    .d_sync (pin_level)
  );

  dio_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_level (pin_level),
    .flags     (flag_q),
    .dir_q     (dir_q),
    .out_q     (out_q),
    .ien_q     (ien_q)
  );

  dio_flags #(.NPINS(NPINS)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .pin_level (pin_level),
    .dir_q     (dir_q),
    .ien_q     (ien_q),
    .flag_rd   (flag_rd),
    .change    (change),
    .flag_q    (flag_q),
    .irq_q     (irq_o)
  );

  assign pad_oe  = dir_q;
  assign pad_out = out_q;
endmodule

// File: rtl/dio_port_chk.sv
module dio_port_chk
  import dio_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int DW    = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic              irq_o,
  input logic [NPINS-1:0]  flag_q,
  input logic [NPINS-1:0]  ien_q,
  input logic [NPINS-1:0]  change
);
  logic wr_dir, wr_data, rd_flag;
  assign wr_dir  = bus_sel & bus_wr & (bus_addr == REG_DIR);
  assign wr_data = bus_sel & bus_wr & (bus_addr == REG_DATA);
  assign rd_flag = bus_sel & bus_rd & (bus_addr == REG_FLAG);

  p_reset_inputs_r1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && !irq_o));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> pad_oe == $past(bus_wdata[NPINS-1:0]));

  p_inputs_kept_r3: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> ((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0);

  p_flag_source_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flag_q & ~$past(flag_q) & ~($past(ien_q) & ~$past(pad_oe))) == '0);

  p_irq_or_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|flag_q));

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !rd_flag) |=> irq_o);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    rd_flag |=> flag_q == $past(change));
endmodule

bind dio_port dio_port_chk #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq_o     (irq_o),
  .flag_q    (flag_q),
  .ien_q     (ien_q),
  .change    (change)
);

// File: tb/dio_port_tb.sv
`timescale 1ns/1ps
module dio_port_tb;
  localparam int NPINS = 8;
  localparam int DW    = 16;
  localparam int NVEC  = 6;

  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] wdata;
    logic [7:0] pins;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{dir: 8'hFF, wdata: 8'hA5, pins: 8'h00},
    '{dir: 8'h0F, wdata: 8'h3C, pins: 8'hFF},
    '{dir: 8'hF0, wdata: 8'hFF, pins: 8'h0A},
    '{dir: 8'h00, wdata: 8'h00, pins: 8'h55},
    '{dir: 8'hAA, wdata: 8'h0F, pins: 8'h33},
    '{dir: 8'h81, wdata: 8'h7E, pins: 8'hC3}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]       bus_addr = '0;
  logic [DW-1:0]    bus_wdata = '0;
  logic [DW-1:0]    bus_rdata;
  logic [NPINS-1:0] pad_in = '0;
  logic [NPINS-1:0] pad_out, pad_oe;
  logic             irq_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  logic [7:0] model_out = '0;
  logic [DW-1:0] rv;

  always #2.5 clk = ~clk;

  dio_port #(.NPINS(NPINS), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 0);
    check("R1 pad_out", pad_out, 0);
    check("R1 irq", irq_o, 0);
    bus_read(2'd3, rv); check("R1 flags", rv, 0);
    bus_read(2'd0, rv); check("R1 dir", rv, 0);

    // Vector walk: R2 direction, R3 masked data write, R4 data read
    foreach (VECS[k]) begin
      bus_write(2'd0, {8'h00, VECS[k].dir});
      check("R2 pad_oe", pad_oe, VECS[k].dir);
      bus_write(2'd1, {8'h00, VECS[k].wdata});
      model_out = (VECS[k].wdata & VECS[k].dir) | (model_out & ~VECS[k].dir);
      check("R3 pad_out", pad_out, model_out);
      pad_in = VECS[k].pins;
      idle(4);
      bus_read(2'd1, rv);
      check("R4 data read", rv, {8'h00, (VECS[k].dir & model_out) | (~VECS[k].dir & VECS[k].pins)});
      bus_read(2'd0, rv);
      check("R2 dir read", rv, {8'h00, VECS[k].dir});
      check("R5 no flag with enables off", irq_o, 0);
    end

    // Interrupt setup: pin 7 output, others input; enable pins 0,1,2,7
    pad_in = 8'h00;
    bus_write(2'd0, 16'h0080);
    idle(4);
    bus_read(2'd3, rv);
    bus_write(2'd2, 16'h0087);
    bus_read(2'd2, rv); check("R8 enable reads zero", rv, 0);

    // R5: non-enabled input and output pin changes set nothing
    pad_in = 8'h90;
    idle(5);
    check("R5 ignored changes irq", irq_o, 0);
    bus_read(2'd3, rv); check("R5 ignored changes flags", rv, 0);

    // R9 latency + R5 rising edge on pin 0
    @(negedge clk); pad_in = 8'h91;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 irq not before third edge", irq_o, 0);
    @(posedge clk); @(negedge clk);
    check("R9 irq on third edge", irq_o, 1);
    idle(3);
    check("R6 irq held", irq_o, 1);

    // R7: change on pin 1 captured in the same cycle as a flag read
    @(negedge clk); pad_in = 8'h93;
    @(posedge clk); @(posedge clk);
    bus_read(2'd3, rv);
    check("R7 read returns old flags", rv, 16'h0001);
    check("R6 irq stays for preserved flag", irq_o, 1);
    bus_read(2'd3, rv);
    check("R7 preserved flag", rv, 16'h0002);
    check("R6 irq drops after clear", irq_o, 0);
    bus_read(2'd3, rv);
    check("R7 flags cleared", rv, 0);

    // R5 falling edge on pin 0; R8 flag register write ignored
    pad_in = 8'h92;
    idle(5);
    check("R5 falling edge irq", irq_o, 1);
    bus_write(2'd3, 16'h00FF);
    bus_write(2'd3, 16'h0000);
    check("R8 write keeps irq", irq_o, 1);
    bus_read(2'd3, rv);
    check("R8 flag write ignored", rv, 16'h0001);

    // R3: write data while pins mixed; input bits unchanged
    bus_write(2'd1, 16'h00FF);
    model_out = (8'hFF & 8'h80) | (model_out & ~8'h80);
    check("R3 only output bit written", pad_out, model_out);

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    idle(2); rst = 1'b0; idle(1);
    check("R1 reset pad_oe", pad_oe, 0);
    check("R1 reset pad_out", pad_out, 0);
    check("R1 reset irq", irq_o, 0);

    finish_run();
  end
endmodule